// File: doc/BRIEF.md
# Clock-ratio word serializer

The block turns a parallel word, presented once per slow-clock cycle, into a single-bit stream timed by a fast clock that runs at an integer multiple of the slow clock. A slow-domain register captures the word. In the fast domain, a free-running phase counter picks one load edge per word. That edge sits half a word away from the slow-clock boundary, so the hand-over between the two domains keeps a wide margin even when the slow clock is not edge-aligned with the fast clock. Bit 0 leaves first and the higher bits follow in ascending order. Consecutive words run back to back with no idle bits between them.

The serializer has two rates. In single-rate mode one bit goes out per fast period. In double-rate mode two bits go out per fast period: the even-numbered bit while the fast clock is high and the odd-numbered bit while it is low, so the word is twice the clock ratio wide. A small sequencer in the fast domain has two states. `ST_IDLE` is entered on reset, and the sequencer leaves it for `ST_STREAM` on the transition `first_load`, which is the first load edge after reset. The sequencer stays in `ST_STREAM` until the next reset.

Top module: `ser_word_serializer`

## Requirements
- R1: While `rst` (active high, synchronous in both domains) is sampled high, the captured word, the phase counter and every shift lane clear to zero, so `dout` is 0.
- R2: In single-rate mode (`RATE`=1), bit 0 of a word is driven first and bit i is driven i fast periods after bit 0, which is least significant bit first.
- R3: With `RATIO`=8, `RATE`=1 and an 8-bit word, exactly one load happens every 8 fast periods, and consecutive words follow each other with no gap.
- R4: In double-rate mode (`RATE`=2, 16-bit word, `RATIO`=8), bit 2k is on `dout` while `clk_fast` is high and bit 2k+1 while it is low, in fast period k after the load.
- R5: With the slow and fast clocks edge-aligned and `din` changed just after a slow rising edge, bit 0 of that word appears at the fast rising edge `RATIO+LOAD_PHASE+1` fast periods after that slow edge (13 with the defaults). Here `LOAD_PHASE` = `RATIO/2` is the counter value that selects the load edge.
- R6: When the slow clock lags the data-driving clock by less than one fast period, the captured word reaches `dout` exactly one word time (`RATIO` fast periods) earlier than in R5.
- R7: An all-zero word that follows data words produces a serial stream of zeros for its whole word time.
- R8: After reset the sequencer is in `ST_IDLE` with `dout` low until the first load edge. It then takes `first_load` into `ST_STREAM` and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock; the word rate |
| clk_fast | input | 1 | Fast clock, `RATIO` times the slow clock |
| rst | input | 1 | Active-high synchronous reset, seen by both domains |
| din | input | WIDTH | Parallel word, WIDTH = RATIO*RATE |
| dout | output | 1 | Serial bit stream, least significant bit first |

## Verification
The bench elaborates four copies of the block. Two use `RATIO`=8 and `RATE`=1, an 8-bit word driven one bit per fast period. The other two use `RATIO`=8 and `RATE`=2, a 16-bit word driven on both fast-clock phases. Within each pair, one copy has a slow clock aligned with the fast clock and the other has a slow clock delayed by a quarter fast period. This puts the nominal latency and the one-word-shorter latency within reach for both rates. Each copy checks exact bit positions against start times derived from `RATIO` and `LOAD_PHASE`. The same words, random and directed, go to both copies of each pair. The directed words include a single low bit, a single high bit, all ones, an alternating pattern and trailing zeros.

// File: rtl/ser_pkg.sv
`timescale 1ps/1ps
package ser_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } seq_state_t;

    // position inside the word of bit 'pos' of lane 'lane'
    function automatic int lane_bit_index(input int lane, input int pos, input int rate);
        return pos * rate + lane;
    endfunction

endpackage

// File: rtl/ser_word_capture.sv
`timescale 1ps/1ps
module ser_word_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk_slow,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] hold
);

    always_ff @(posedge clk_slow) begin
        if (rst) begin
            hold <= '0;
        end else begin
            hold <= din;
        end
    end

    // R1: reset clears the captured word
    p_hold_clear_r1: assert property (@(posedge clk_slow) rst |=> hold == '0)
        else $error("p_hold_clear_r1");

endmodule

// File: rtl/ser_phase_seq.sv
`timescale 1ps/1ps
module ser_phase_seq
    import ser_pkg::*;
#(
    parameter int RATIO      = 8,
    parameter int LOAD_PHASE = RATIO / 2
) (
    input  logic       clk_fast,
    input  logic       rst,
    output logic       load,
    output seq_state_t state
);

    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [CW-1:0] cnt;
    seq_state_t    state_nxt;

    // free-running phase counter, wraps once per word
    always_ff @(posedge clk_fast) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == CW'(RATIO - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk_fast) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        load      = (cnt == CW'(LOAD_PHASE));
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (load) state_nxt = ST_STREAM; // first_load
            ST_STREAM: state_nxt = ST_STREAM;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // R3: one load edge per word, never two in a row
    p_one_load_per_word_r3: assert property (@(posedge clk_fast) disable iff (rst)
        load |=> !load)
        else $error("p_one_load_per_word_r3");

    // R8: streaming state is kept until reset
    p_stream_sticky_r8: assert property (@(posedge clk_fast) disable iff (rst)
        state == ST_STREAM |=> state == ST_STREAM)
        else $error("p_stream_sticky_r8");

endmodule

// File: rtl/ser_lane_shift.sv
`timescale 1ps/1ps
module ser_lane_shift #(
    parameter int BITS = 8
) (
    input  logic            clk_fast,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] word,
    output logic            head
);

    logic [BITS-1:0] lane_q;

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            lane_q <= '0;
        end else if (load) begin
            lane_q <= word;
        end else begin
            lane_q <= {1'b0, lane_q[BITS-1:1]};
        end
    end

    assign head = lane_q[0];

endmodule

// File: rtl/ser_word_serializer.sv
`timescale 1ps/1ps
module ser_word_serializer
    import ser_pkg::*;
#(
    parameter int RATIO      = 8,
    parameter int RATE       = 1,
    parameter int LOAD_PHASE = RATIO / 2,
    parameter int WIDTH      = RATIO * RATE
) (
    input  logic             clk_slow,
    input  logic             clk_fast,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic             dout
);

    localparam int LANE_BITS = WIDTH / RATE;

    logic [WIDTH-1:0] hold;
    logic             ld;
    seq_state_t       state;
    logic [RATE-1:0]  head;

    ser_word_capture #(.WIDTH(WIDTH)) u_capture (
        .clk_slow (clk_slow),
        .rst      (rst),
        .din      (din),
        .hold     (hold)
    );

    ser_phase_seq #(.RATIO(RATIO), .LOAD_PHASE(LOAD_PHASE)) u_seq (
        .clk_fast (clk_fast),
        .rst      (rst),
        .load     (ld),
        .state    (state)
    );

    // lane r carries word bits r, r+RATE, r+2*RATE, ...
    for (genvar r = 0; r < RATE; r++) begin : g_lane
        logic [LANE_BITS-1:0] lane_word;
        for (genvar p = 0; p < LANE_BITS; p++) begin : g_pick
            assign lane_word[p] = hold[lane_bit_index(r, p, RATE)];
        end
        ser_lane_shift #(.BITS(LANE_BITS)) u_lane (
            .clk_fast (clk_fast),
            .rst      (rst),
            .load     (ld),
            .word     (lane_word),
            .head     (head[r])
        );
    end

    if (RATE == 2) begin : g_double
        // high phase carries the even bit, low phase the odd bit
        assign dout = clk_fast ? head[0] : head[RATE-1];
    end else begin : g_single
        assign dout = head[0];
    end

    // R2: bit 0 of the captured word is the first bit after a load
    p_first_bit_r2: assert property (@(posedge clk_fast) disable iff (rst)
        ld |=> head[0] == $past(hold[0]))
        else $error("p_first_bit_r2");

    // R6: the captured word is settled across the load edge
    p_hold_settled_r6: assert property (@(posedge clk_fast) disable iff (rst)
        ld |-> $stable(hold))
        else $error("p_hold_settled_r6");

    // R8: nothing leaves the lanes before the first load
    p_idle_quiet_r8: assert property (@(posedge clk_fast) disable iff (rst)
        state == ST_IDLE |-> head == '0)
        else $error("p_idle_quiet_r8");

endmodule

// File: tb/ser_word_serializer_test.sv
`timescale 1ps/1ps
module ser_word_serializer_test;

    localparam int  NW       = 12;
    localparam int  RATIO    = 8;
    localparam int  LPH      = RATIO / 2;
    localparam int  FAST_PS  = 1000;
    localparam int  SLOW_PS  = FAST_PS * RATIO; // 8 ns: 125 MHz
    localparam int  SKEW_PS  = 250;

    logic clk_fast = 1'b0;
    logic clk_slow = 1'b0;
    logic clk_dly  = 1'b0;
    logic rst      = 1'b1;
    logic [7:0]  din8  = '0;
    logic [15:0] din16 = '0;
    logic d8, d8d, d16, d16d;

    int checks = 0;
    int fails  = 0;
    longint t_edge;
    logic [7:0]  w8  [NW];
    logic [15:0] w16 [NW];

    always #(FAST_PS/2) clk_fast = ~clk_fast;
    initial begin
        #(FAST_PS/2);
        forever begin
            clk_slow = 1'b1; #(SLOW_PS/2);
            clk_slow = 1'b0; #(SLOW_PS/2);
        end
    end
    always @(clk_slow) clk_dly <= #(SKEW_PS) clk_slow;

    ser_word_serializer #(.RATIO(RATIO), .RATE(1)) uut (
        .clk_slow(clk_slow), .clk_fast(clk_fast), .rst(rst), .din(din8), .dout(d8));
    ser_word_serializer #(.RATIO(RATIO), .RATE(1)) uut_dly8 (
        .clk_slow(clk_dly), .clk_fast(clk_fast), .rst(rst), .din(din8), .dout(d8d));
    ser_word_serializer #(.RATIO(RATIO), .RATE(2)) uut_ddr (
        .clk_slow(clk_slow), .clk_fast(clk_fast), .rst(rst), .din(din16), .dout(d16));
    ser_word_serializer #(.RATIO(RATIO), .RATE(2)) uut_ddr_dly (
        .clk_slow(clk_dly), .clk_fast(clk_fast), .rst(rst), .din(din16), .dout(d16d));

    function automatic logic pick(input int s);
        case (s)
            0: return d8;
            1: return d8d;
            2: return d16;
            default: return d16d;
        endcase
    endfunction

    // expected serial bit i of a word: least significant bit first
    function automatic logic exp_bit(input logic [15:0] w, input int i);
        return w[i];
    endfunction

    task automatic wait_until(input longint t);
        if (t > $time) #(t - $time);
    endtask

    task automatic check_zero_window(input int s, input longint t0, input longint t1);
        int bad = 0;
        for (longint t = t0; t < t1; t += 250) begin
            wait_until(t);
            if (pick(s) !== 1'b0) bad++;
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL R1/R8 inst=%0d dout before first load: actual=%0d nonzero samples expected=0", s, bad);
        end
    endtask

    task automatic check_stream(input int s, input int width, input longint start, input string tag);
        int bit_ps = FAST_PS * 8 / width;
        for (int k = 0; k < NW; k++) begin
            logic [15:0] got = '0;
            logic [15:0] exp = '0;
            for (int i = 0; i < width; i++) begin
                exp[i] = exp_bit((width == 8) ? {8'h00, w8[k]} : w16[k], i);
                wait_until(start + longint'(k) * SLOW_PS + longint'(i) * bit_ps + bit_ps / 2);
                got[i] = pick(s);
            end
            checks++;
            if (got !== exp) begin
                fails++;
                $display("FAIL %s%s inst=%0d word=%0d actual=%h expected=%h",
                         tag, (k >= NW - 2) ? "/R7" : "", s, k, got, exp);
            end
        end
    endtask

    initial begin : watchdog
        #(2_000_000);
        fails++;
        $display("FAIL R5 watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int unsigned seed_v;
        longint g0;
        seed_v = $urandom(32'd20417);
        // directed words first, random in the middle, zeros last
        w8[0] = 8'hFF;  w16[0] = 16'hFFFF;
        w8[1] = 8'h01;  w16[1] = 16'h0001;
        w8[2] = 8'h80;  w16[2] = 16'h8000;
        w8[3] = 8'hAA;  w16[3] = 16'h5555;
        w8[4] = 8'h33;  w16[4] = 16'hCCCC;
        for (int k = 5; k < NW - 2; k++) begin
            w8[k]  = 8'($urandom());
            w16[k] = 16'($urandom());
        end
        w8[NW-2] = '0; w16[NW-2] = '0;
        w8[NW-1] = '0; w16[NW-1] = '0;

        repeat (3) @(posedge clk_slow);
        t_edge = $time;
        #100 rst = 1'b0;
        g0 = t_edge + SLOW_PS;

        fork
            begin : drive
                for (int k = 0; k < NW + 3; k++) begin
                    @(posedge clk_slow);
                    #100;
                    din8  = (k < NW) ? w8[k]  : 8'h00;
                    din16 = (k < NW) ? w16[k] : 16'h0000;
                end
            end
            begin : chk_a8
                check_zero_window(0, t_edge + 200, g0 + (LPH + 1) * FAST_PS);
                check_stream(0, 8, g0 + (RATIO + LPH + 1) * FAST_PS, "R2/R3/R5");
            end
            begin : chk_d8
                check_zero_window(1, t_edge + 200, g0 + (LPH + 1) * FAST_PS);
                check_stream(1, 8, g0 + (LPH + 1) * FAST_PS, "R2/R6");
            end
            begin : chk_a16
                check_zero_window(2, t_edge + 200, g0 + (LPH + 1) * FAST_PS);
                check_stream(2, 16, g0 + (RATIO + LPH + 1) * FAST_PS, "R4/R5");
            end
            begin : chk_d16
                check_zero_window(3, t_edge + 200, g0 + (LPH + 1) * FAST_PS);
                check_stream(3, 16, g0 + (LPH + 1) * FAST_PS, "R4/R6");
            end
        join

        // R1: reset again mid-stream clears the output
        rst = 1'b1;
        din8 = 8'hFF; din16 = 16'hFFFF;
        repeat (2) @(posedge clk_slow);
        #300;
        for (int s = 0; s < 4; s++) begin
            checks++;
            if (pick(s) !== 1'b0) begin
                fails++;
                $display("FAIL R1 inst=%0d dout under reset actual=%b expected=0", s, pick(s));
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule